// File: doc/BRIEF.md
# Mask-Driven GPIO Port with Level Alarms

This block is a general-purpose I/O port of 8 to 32 bits in which every bit has its own direction. Software reaches it through a small set of command strobes that share one mask word. Each command acts only on the bits whose mask bit is 1 and leaves the rest alone. One command drives selected outputs high and another drives them low. Two commands move selected bits to input or to output. Three more arm a high-level alarm, arm a low-level alarm, or disarm both alarm types.

Pin inputs pass through a two-flop synchronizer. The synchronized pins, the output shadow, the direction word and the alarm status can each be read back, with a fixed one-cycle latency. A direction command also returns the updated direction mask on a response port. An alarm bit becomes pending when its armed level is seen on the pin. It stays pending until software disarms it, and the interrupt is high while any bit is pending.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset every bit is an input (`pin_oe` = 0), the output shadow is 0, no alarm is armed or pending, and `irq` is 0.
- R2: A set-bits strobe drives to 1 every shadow bit whose mask bit is 1, from the next cycle on. With no set-bits or clear-bits strobe, `pin_out` holds its value.
- R3: A clear-bits strobe drives to 0 every shadow bit whose mask bit is 1. When set-bits and clear-bits are strobed in the same cycle, clear wins for the bits both touch.
- R4: A set-to-input strobe makes the masked bits inputs (direction 0). On the next cycle `resp_valid` pulses and `resp_data` carries the updated input mask, which is the bitwise inverse of the direction word. When set-to-input and set-to-output are strobed in the same cycle, input wins.
- R5: A set-to-output strobe makes the masked bits outputs (direction 1) and drives `pin_oe` from the next cycle on. Its response carries the updated output mask.
- R6: A read strobe returns data on the next cycle, with `rd_valid` high for exactly that cycle. The select values are 0 for synchronized pins, 1 for the output shadow, 2 for the direction word (1 = output) and 3 for the pending-alarm status.
- R7: Pins are sampled by two flops. A read captured at the first or second clock edge after a pin changes still returns the old value. A read captured at the third edge returns the new value.
- R8: Arm-high ORs the masked bits into the high-alarm set. An armed bit whose synchronized pin is 1 becomes pending.
- R9: Arm-low ORs the masked bits into the low-alarm set. An armed bit whose synchronized pin is 0 becomes pending.
- R10: A pending bit stays pending after its pin level goes away. Clear-alarm disarms both alarm types for the masked bits and drops their pending state. Clear wins over an arm strobe in the same cycle, and `irq` is 1 exactly while some bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output shadow driven to pads |
| pin_oe | output | WIDTH | Per-bit output enable (1 = output) |
| wr_mask | input | WIDTH | Mask shared by all command strobes |
| set_bits_stb | input | 1 | Drive masked outputs high |
| clr_bits_stb | input | 1 | Drive masked outputs low |
| set_in_stb | input | 1 | Make masked bits inputs |
| set_out_stb | input | 1 | Make masked bits outputs |
| arm_hi_stb | input | 1 | Arm high-level alarm on masked bits |
| arm_lo_stb | input | 1 | Arm low-level alarm on masked bits |
| clr_alarm_stb | input | 1 | Disarm both alarms on masked bits |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Read select (0 pins, 1 shadow, 2 direction, 3 alarm status) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WIDTH | Read data |
| resp_valid | output | 1 | Direction command response valid |
| resp_data | output | WIDTH | Updated input or output mask |
| irq | output | 1 | Alarm interrupt |

## Verification
The properties assume that the command strobes and `rd_en` are low while the internal reset is active and during the first cycle after it lifts, so no `$past` term reaches a value from the reset period. They also assume that `wr_mask` is a stable, known value whenever a strobe is high. The stimulus changes strobes and mask only at falling edges and holds everything idle through reset and several cycles beyond. It changes `pin_in` only on falling edges as well, so the synchronizer latency seen by the reads is exact.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

  // Number of flops on each pin input before it is used.
  localparam int unsigned SYNC_STAGES = 2;

  // Read select codes.
  typedef enum logic [1:0] {
    RD_PINS   = 2'd0,
    RD_SHADOW = 2'd1,
    RD_DIR    = 2'd2,
    RD_ALARM  = 2'd3
  } rd_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  // First stage takes the raw pins; later stages take the stage before.
  always_comb begin
    stage_d[0] = async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_comb begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_out = stage_q[LAST];

endmodule

// File: rtl/gpio_io_regs.sv
module gpio_io_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             set_bits_stb,
  input  logic             clr_bits_stb,
  input  logic             set_in_stb,
  input  logic             set_out_stb,
  output logic [WIDTH-1:0] shadow,
  output logic [WIDTH-1:0] dir,
  output logic             resp_valid,
  output logic [WIDTH-1:0] resp_data
);

  logic [WIDTH-1:0] shadow_q, shadow_d;
  logic [WIDTH-1:0] dir_q, dir_d;
  logic             resp_vld_q, resp_vld_d;
  logic [WIDTH-1:0] resp_q, resp_d;
  logic             shadow_en, dir_en;
  logic [WIDTH-1:0] set_mask, clr_mask;
  logic [WIDTH-1:0] in_mask, out_mask;

  // Output shadow: clear has priority over set on shared bits.
  always_comb begin
    set_mask  = set_bits_stb ? wr_mask : '0;
    clr_mask  = clr_bits_stb ? wr_mask : '0;
    shadow_en = set_bits_stb | clr_bits_stb;
    shadow_d  = (shadow_q | set_mask) & ~clr_mask;
  end

  // Direction: 1 = output; input request has priority.
  always_comb begin
    in_mask  = set_in_stb  ? wr_mask : '0;
    out_mask = set_out_stb ? wr_mask : '0;
    dir_en   = set_in_stb | set_out_stb;
    dir_d    = (dir_q | out_mask) & ~in_mask;
  end

  // Response carries the mask of the kind that was requested.
  always_comb begin
    resp_vld_d = dir_en;
    resp_d     = resp_q;
    if (set_in_stb) begin
      resp_d = ~dir_d;
    end else if (set_out_stb) begin
      resp_d = dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
    end else if (dir_en) begin
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_vld_q <= 1'b0;
      resp_q     <= '0;
    end else begin
      resp_vld_q <= resp_vld_d;
      if (dir_en) begin
        resp_q <= resp_d;
      end
    end
  end

  assign shadow     = shadow_q;
  assign dir        = dir_q;
  assign resp_valid = resp_vld_q;
  assign resp_data  = resp_q;

endmodule

// File: rtl/gpio_alarm_regs.sv
module gpio_alarm_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             arm_hi_stb,
  input  logic             arm_lo_stb,
  input  logic             clr_alarm_stb,
  output logic [WIDTH-1:0] pending,
  output logic             irq
);

  logic [WIDTH-1:0] arm_hi_q, arm_hi_d;
  logic [WIDTH-1:0] arm_lo_q, arm_lo_d;
  logic [WIDTH-1:0] pend_q, pend_d;
  logic [WIDTH-1:0] hit;
  logic [WIDTH-1:0] disarm;
  logic             arm_en;

  // Arm sets; disarm clears both kinds and wins over an arm.
  always_comb begin
    disarm   = clr_alarm_stb ? wr_mask : '0;
    arm_en   = arm_hi_stb | arm_lo_stb | clr_alarm_stb;
    arm_hi_d = (arm_hi_q | (arm_hi_stb ? wr_mask : '0)) & ~disarm;
    arm_lo_d = (arm_lo_q | (arm_lo_stb ? wr_mask : '0)) & ~disarm;
  end

  // Per-bit level match, sticky until the bit is no longer armed.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      hit[b]    = (arm_hi_q[b] & pins[b]) | (arm_lo_q[b] & ~pins[b]);
      pend_d[b] = (pend_q[b] | hit[b]) & (arm_hi_d[b] | arm_lo_d[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_hi_q <= '0;
      arm_lo_q <= '0;
    end else if (arm_en) begin
      arm_hi_q <= arm_hi_d;
      arm_lo_q <= arm_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
  assign irq     = |pend_q;

endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
  import gpio_alarm_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  input  logic [WIDTH-1:0] pins,
  input  logic [WIDTH-1:0] shadow,
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] pending,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data
);

  logic             vld_q;
  logic [WIDTH-1:0] data_q, data_d;
  rd_sel_e          sel;

  always_comb begin
    sel = rd_sel_e'(rd_sel);
    unique case (sel)
      RD_PINS:   data_d = pins;
      RD_SHADOW: data_d = shadow;
      RD_DIR:    data_d = dir;
      RD_ALARM:  data_d = pending;
      default:   data_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) begin
        data_q <= data_d;
      end
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = data_q;

endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
  import gpio_alarm_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             set_bits_stb,
  input  logic             clr_bits_stb,
  input  logic             set_in_stb,
  input  logic             set_out_stb,
  input  logic             arm_hi_stb,
  input  logic             arm_lo_stb,
  input  logic             clr_alarm_stb,
  input  logic             rd_en,
  input  logic [1:0]       rd_sel,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             resp_valid,
  output logic [WIDTH-1:0] resp_data,
  output logic             irq
);

  logic [1:0]       rst_pipe_q;
  logic             rst_ni;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] shadow;
  logic [WIDTH-1:0] dir;
  logic [WIDTH-1:0] pending;

  // Reset asserts at once and lifts two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_pipe_q[1];

  gpio_pin_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_io_regs #(
    .WIDTH (WIDTH)
  ) u_io (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .wr_mask      (wr_mask),
    .set_bits_stb (set_bits_stb),
    .clr_bits_stb (clr_bits_stb),
    .set_in_stb   (set_in_stb),
    .set_out_stb  (set_out_stb),
    .shadow       (shadow),
    .dir          (dir),
    .resp_valid   (resp_valid),
    .resp_data    (resp_data)
  );

  gpio_alarm_regs #(
    .WIDTH (WIDTH)
  ) u_alarm (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .pins          (pins_sync),
    .wr_mask       (wr_mask),
    .arm_hi_stb    (arm_hi_stb),
    .arm_lo_stb    (arm_lo_stb),
    .clr_alarm_stb (clr_alarm_stb),
    .pending       (pending),
    .irq           (irq)
  );

  gpio_readback #(
    .WIDTH (WIDTH)
  ) u_rd (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .pins     (pins_sync),
    .shadow   (shadow),
    .dir      (dir),
    .pending  (pending),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign pin_out = shadow;
  assign pin_oe  = dir;

endmodule

// File: rtl/gpio_alarm_port_chk.sv
module gpio_alarm_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [WIDTH-1:0] wr_mask,
  input logic             set_bits_stb,
  input logic             clr_bits_stb,
  input logic             set_in_stb,
  input logic             set_out_stb,
  input logic             clr_alarm_stb,
  input logic             rd_en,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             rd_valid,
  input logic             resp_valid,
  input logic [WIDTH-1:0] resp_data,
  input logic             irq
);

  assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_bits_stb && !clr_bits_stb) |=> ((pin_out & $past(wr_mask)) == $past(wr_mask)));

  assert_shadow_holds_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (!set_bits_stb && !clr_bits_stb) |=> $stable(pin_out));

  assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_bits_stb |=> ((pin_out & $past(wr_mask)) == '0));

  assert_input_masked_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    set_in_stb |=> ((pin_oe & $past(wr_mask)) == '0));

  assert_input_resp_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    set_in_stb |=> (resp_valid && (resp_data == ~pin_oe)));

  assert_output_masked_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (set_out_stb && !set_in_stb) |=> ((pin_oe & $past(wr_mask)) == $past(wr_mask)));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_en |=> rd_valid);

  assert_read_idle_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> !rd_valid);

  assert_full_disarm_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_alarm_stb && (wr_mask == '1)) |=> !irq);

endmodule

bind gpio_alarm_port gpio_alarm_port_chk #(
  .WIDTH (WIDTH)
) u_chk (
  .clk           (clk),
  .rst_ni        (rst_ni),
  .wr_mask       (wr_mask),
  .set_bits_stb  (set_bits_stb),
  .clr_bits_stb  (clr_bits_stb),
  .set_in_stb    (set_in_stb),
  .set_out_stb   (set_out_stb),
  .clr_alarm_stb (clr_alarm_stb),
  .rd_en         (rd_en),
  .pin_out       (pin_out),
  .pin_oe        (pin_oe),
  .rd_valid      (rd_valid),
  .resp_valid    (resp_valid),
  .resp_data     (resp_data),
  .irq           (irq)
);

// File: tb/gpio_alarm_port_bench.sv
module gpio_alarm_port_bench;

  localparam int unsigned W = 8;

  // Strobe bit positions used by the driver task.
  localparam int unsigned S_SET = 0, S_CLR = 1, S_IN = 2, S_OUT = 3,
                          S_AHI = 4, S_ALO = 5, S_ACLR = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic [W-1:0] wr_mask = '0;
  logic         set_bits_stb = 1'b0, clr_bits_stb = 1'b0;
  logic         set_in_stb = 1'b0, set_out_stb = 1'b0;
  logic         arm_hi_stb = 1'b0, arm_lo_stb = 1'b0, clr_alarm_stb = 1'b0;
  logic         rd_en = 1'b0;
  logic [1:0]   rd_sel = '0;
  logic         rd_valid, resp_valid, irq;
  logic [W-1:0] rd_data, resp_data;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  bit          finished = 1'b0;

  // Reference state computed from the requirements.
  logic [W-1:0] m_shadow = '0, m_dir = '0, m_hi = '0, m_lo = '0;
  logic [W-1:0] m_pend = '0, m_pins = '0;

  // Scoreboard queues.
  logic [W-1:0] rd_exp_q[$];
  string        rd_tag_q[$];
  logic [W-1:0] rsp_exp_q[$];
  string        rsp_tag_q[$];

  always #2 clk = ~clk;

  gpio_alarm_port #(.WIDTH(W)) u_gpio_alarm_port (
    .clk (clk), .rst_n (rst_n), .pin_in (pin_in), .pin_out (pin_out),
    .pin_oe (pin_oe), .wr_mask (wr_mask), .set_bits_stb (set_bits_stb),
    .clr_bits_stb (clr_bits_stb), .set_in_stb (set_in_stb),
    .set_out_stb (set_out_stb), .arm_hi_stb (arm_hi_stb),
    .arm_lo_stb (arm_lo_stb), .clr_alarm_stb (clr_alarm_stb),
    .rd_en (rd_en), .rd_sel (rd_sel), .rd_valid (rd_valid),
    .rd_data (rd_data), .resp_valid (resp_valid), .resp_data (resp_data),
    .irq (irq)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare outputs against queued expectations.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (rd_exp_q.size() == 0) begin
          check("R6 unexpected rd_valid", 8'h01, 8'h00);
        end else begin
          check(rd_tag_q.pop_front(), rd_data, rd_exp_q.pop_front());
        end
      end
      if (resp_valid) begin
        if (rsp_exp_q.size() == 0) begin
          check("R4 unexpected resp_valid", 8'h01, 8'h00);
        end else begin
          check(rsp_tag_q.pop_front(), resp_data, rsp_exp_q.pop_front());
        end
      end
    end
  end

  function automatic logic [W-1:0] hits();
    return (m_hi & m_pins) | (m_lo & ~m_pins);
  endfunction

  // Driver: one command cycle plus one settle cycle; updates the model.
  task automatic do_cmd(input logic [6:0] stb, input logic [W-1:0] mask, input string tag);
    logic [W-1:0] mk;
    mk = mask;
    wr_mask       = mask;
    set_bits_stb  = stb[S_SET];
    clr_bits_stb  = stb[S_CLR];
    set_in_stb    = stb[S_IN];
    set_out_stb   = stb[S_OUT];
    arm_hi_stb    = stb[S_AHI];
    arm_lo_stb    = stb[S_ALO];
    clr_alarm_stb = stb[S_ACLR];
    if (stb[S_SET]) m_shadow = m_shadow | mk;
    if (stb[S_CLR]) m_shadow = m_shadow & ~mk;
    if (stb[S_OUT]) m_dir = m_dir | mk;
    if (stb[S_IN])  m_dir = m_dir & ~mk;
    if (stb[S_IN]) begin
      rsp_exp_q.push_back(~m_dir); rsp_tag_q.push_back({tag, " resp"});
    end else if (stb[S_OUT]) begin
      rsp_exp_q.push_back(m_dir); rsp_tag_q.push_back({tag, " resp"});
    end
    if (stb[S_AHI]) m_hi = m_hi | mk;
    if (stb[S_ALO]) m_lo = m_lo | mk;
    if (stb[S_ACLR]) begin
      m_hi = m_hi & ~mk;
      m_lo = m_lo & ~mk;
    end
    m_pend = (m_pend | hits()) & (m_hi | m_lo);
    @(negedge clk);
    {set_bits_stb, clr_bits_stb, set_in_stb, set_out_stb} = '0;
    {arm_hi_stb, arm_lo_stb, clr_alarm_stb} = '0;
    wr_mask = '0;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] sel, input logic [W-1:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    rd_en  = 1'b1;
    rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_pins(input logic [W-1:0] v);
    pin_in = v;
    m_pins = v;
    repeat (4) @(negedge clk);
    m_pend = (m_pend | hits()) & (m_hi | m_lo);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", {7'd0, irq}, '0);
    do_read(2'd1, '0, "R1 shadow read");
    do_read(2'd2, '0, "R1 dir read");
    do_read(2'd3, '0, "R1 alarm read");

    // R5 output direction and response
    do_cmd(7'b1 << S_OUT, 8'h0F, "R5 set output");
    check("R5 pin_oe", pin_oe, m_dir);
    // R4 input direction and response
    do_cmd(7'b1 << S_IN, 8'h03, "R4 set input");
    check("R4 pin_oe", pin_oe, m_dir);
    do_cmd((7'b1 << S_IN) | (7'b1 << S_OUT), 8'h30, "R4 input wins");
    do_cmd(7'b1 << S_OUT, 8'hC0, "R5 set output high");
    do_read(2'd2, m_dir, "R6 dir read");

    // R2 / R3 output shadow
    do_cmd(7'b1 << S_SET, 8'hA5, "R2 set bits");
    check("R2 pin_out", pin_out, m_shadow);
    do_cmd(7'b1 << S_CLR, 8'h21, "R3 clear bits");
    check("R3 pin_out", pin_out, m_shadow);
    do_cmd((7'b1 << S_SET) | (7'b1 << S_CLR), 8'h0F, "R3 clear wins");
    check("R3 clear wins pin_out", pin_out, m_shadow);
    do_read(2'd1, m_shadow, "R6 shadow read");

    // R7 synchronizer latency
    drive_pins(8'h5A);
    do_read(2'd0, 8'h5A, "R7 pins read");
    pin_in = 8'h3C;
    rd_exp_q.push_back(8'h5A); rd_tag_q.push_back("R7 first edge old");
    rd_exp_q.push_back(8'h5A); rd_tag_q.push_back("R7 second edge old");
    rd_exp_q.push_back(8'h3C); rd_tag_q.push_back("R7 third edge new");
    rd_en = 1'b1; rd_sel = 2'd0;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);
    drive_pins(8'h3C);

    // R8 high alarm
    do_cmd(7'b1 << S_AHI, 8'h01, "R8 arm high quiet");
    check("R8 irq quiet", {7'd0, irq}, 8'h00);
    do_cmd(7'b1 << S_AHI, 8'h04, "R8 arm high hit");
    check("R8 irq", {7'd0, irq}, 8'h01);
    do_read(2'd3, m_pend, "R8 status");
    do_cmd(7'b1 << S_ACLR, 8'h04, "R10 disarm");
    check("R10 irq after disarm", {7'd0, irq}, 8'h00);

    // R9 low alarm and R10 stickiness
    do_cmd(7'b1 << S_ALO, 8'h02, "R9 arm low hit");
    do_read(2'd3, m_pend, "R9 status");
    check("R9 irq", {7'd0, irq}, 8'h01);
    drive_pins(8'h3E);
    do_read(2'd3, m_pend, "R10 sticky status");
    check("R10 irq sticky", {7'd0, irq}, 8'h01);
    do_cmd(7'b1 << S_ACLR, 8'hFF, "R10 disarm all");
    check("R10 irq cleared", {7'd0, irq}, 8'h00);
    do_cmd((7'b1 << S_AHI) | (7'b1 << S_ACLR), 8'h08, "R10 clear beats arm");
    do_read(2'd3, m_pend, "R10 clear beats arm status");
    check("R10 irq none", {7'd0, irq}, 8'h00);
    do_cmd(7'b1 << S_ALO, 8'h40, "R9 arm low bit6");
    do_read(2'd3, m_pend, "R9 status bit6");

    repeat (4) @(negedge clk);
    if (rd_exp_q.size() != 0 || rsp_exp_q.size() != 0) begin
      check("R6 scoreboard drained", 8'h01, 8'h00);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule